// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Butterfly

This block performs one radix-2 decimation-in-frequency butterfly per clock on short complex fixed-point words. On a cycle where `in_valid` is high it takes two complex points, P and Q, and one complex twiddle W. Two cycles later it presents P+Q on the upper output pair and (P−Q)·W on the lower output pair, with `out_valid` high. The add/subtract pass runs first. The difference is then rotated by the twiddle. This is the decimation-in-frequency ordering, so a pipeline of these cells can build a larger transform whose output comes out in bit-reversed order.

All data are 4-bit two's-complement integers. The twiddle is a 4-bit two's-complement value with two fraction bits, so the code 4 stands for 1.0 and the range is −2.0 to +1.75. The complex rotation uses four real multipliers. Each 8-bit product is cut down on its own to a 4-bit word: the two fraction bits are dropped, which floors toward minus infinity, and every bit above the 4-bit window is dropped too. The cut products are then combined with one subtractor (real part) and one adder (imaginary part). Every sum and difference wraps modulo 16, and nothing saturates.

Top module: `dif_bfly_r2`

## Requirements
- R1: While `rst_n` is low, and on every edge where it is low, `out_valid` is 0 and all four data outputs are 0. A transfer that is in flight when reset is asserted never appears at the outputs, and neither does an `in_valid` pulse seen during reset.
- R2: For an accepted transfer, `up_re` equals (`p_re`+`q_re`) mod 16 and `up_im` equals (`p_im`+`q_im`) mod 16, both read as 4-bit two's complement.
- R3: The difference D = P−Q used by the lower path wraps modulo 16 in each component. For example, 7−(−8) gives −1, and (−8)+(−1) gives 7 on the upper path.
- R4: With D = P−Q and t(x,w) = ((x·w) >> 2) taken as a signed 4-bit window, `lo_re` = wrap16(t(Dre,`w_re`) − t(Dim,`w_im`)) and `lo_im` = wrap16(t(Dre,`w_im`) + t(Dim,`w_re`)).
- R5: Each product is truncated by an arithmetic shift that floors toward minus infinity, so −1·1 gives −1 and −3·1 gives −1. Product bits above the 4-bit window are discarded, so (−8)·(−8) = 64 gives 0.
- R6: `out_valid` equals `in_valid` delayed by exactly two clock edges. The results for inputs sampled at edge k appear just after edge k+2.
- R7: A new transfer can be accepted on every cycle. Back-to-back and gapped streams each yield the result of their own inputs, with no mixing between neighbours.
- R8: On any edge where `out_valid` is low, the four data outputs keep their previous values. Input values presented with `in_valid` low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs on this cycle form a transfer |
| p_re | input | 4 | Point P, real part |
| p_im | input | 4 | Point P, imaginary part |
| q_re | input | 4 | Point Q, real part |
| q_im | input | 4 | Point Q, imaginary part |
| w_re | input | 4 | Twiddle, real part (two fraction bits) |
| w_im | input | 4 | Twiddle, imaginary part (two fraction bits) |
| out_valid | output | 1 | Outputs carry a result |
| up_re | output | 4 | P+Q, real part |
| up_im | output | 4 | P+Q, imaginary part |
| lo_re | output | 4 | (P−Q)·W, real part |
| lo_im | output | 4 | (P−Q)·W, imaginary part |

## Verification
The bench drives operands that make the difference wrap. A design that widened or saturated the difference would give a wrong sign on the lower outputs. It uses negative products with small magnitude, where truncation toward zero instead of floor would be off by one. It also uses the −2.0 twiddle against −8, whose product overflows the window and must read 0. Gapped streams that toggle the inputs while `in_valid` is low would expose a pipeline that loads every cycle, because its held outputs would change. A reset asserted with transfers still in flight would expose a valid pipe that is not cleared: those transfers would leak out after reset is released.

// File: rtl/dif_bfly_pkg.sv
package dif_bfly_pkg;

    // Default word widths and fixed-point layout of the butterfly.
    localparam int unsigned DATA_W_DEF = 4;
    localparam int unsigned TWID_W_DEF = 4;
    localparam int unsigned FRAC_W_DEF = 2;

    // Pipeline depth: one register after add/subtract, one after multiply.
    localparam int unsigned PIPE_LAT = 2;

endpackage

// File: rtl/dif_bfly_addsub.sv
module dif_bfly_addsub #(
    parameter int unsigned DW = dif_bfly_pkg::DATA_W_DEF
) (
    input  logic signed [DW-1:0] p_re,
    input  logic signed [DW-1:0] p_im,
    input  logic signed [DW-1:0] q_re,
    input  logic signed [DW-1:0] q_im,
    output logic signed [DW-1:0] sum_re,
    output logic signed [DW-1:0] sum_im,
    output logic signed [DW-1:0] dif_re,
    output logic signed [DW-1:0] dif_im
);

    // Results keep DW bits, so every operation wraps modulo 2^DW.
    always_comb begin
        sum_re = p_re + q_re;
        sum_im = p_im + q_im;
        dif_re = p_re - q_re;
        dif_im = p_im - q_im;
    end

endmodule

// File: rtl/dif_bfly_tmul.sv
module dif_bfly_tmul #(
    parameter int unsigned DW   = dif_bfly_pkg::DATA_W_DEF,
    parameter int unsigned TW   = dif_bfly_pkg::TWID_W_DEF,
    parameter int unsigned FRAC = dif_bfly_pkg::FRAC_W_DEF
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [TW-1:0] w,
    output logic signed [DW-1:0] y
);

    localparam int unsigned PW = DW + TW;
    localparam int unsigned HI = FRAC + DW;

    logic signed [PW-1:0] prod;
    logic [PW-HI-1:0]     unused_hi;
    logic [FRAC-1:0]      unused_lo;

    // Full-precision signed product.
    assign prod = $signed({{TW{x[DW-1]}}, x}) * $signed({{DW{w[TW-1]}}, w});

    // Keep the DW-bit window just above the fraction bits. Dropping the
    // low bits floors the result; dropping the high bits wraps it.
    assign y         = prod[HI-1:FRAC];
    assign unused_hi = prod[PW-1:HI];
    assign unused_lo = prod[FRAC-1:0];

endmodule

// File: rtl/dif_bfly_twid.sv
module dif_bfly_twid #(
    parameter int unsigned DW   = dif_bfly_pkg::DATA_W_DEF,
    parameter int unsigned TW   = dif_bfly_pkg::TWID_W_DEF,
    parameter int unsigned FRAC = dif_bfly_pkg::FRAC_W_DEF
) (
    input  logic signed [DW-1:0] d_re,
    input  logic signed [DW-1:0] d_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [DW-1:0] r_re,
    output logic signed [DW-1:0] r_im
);

    localparam int unsigned NMUL = 4;

    // Product index: bit 1 selects the data part, bit 0 the twiddle part.
    // 0: d_re*w_re  1: d_re*w_im  2: d_im*w_re  3: d_im*w_im
    logic signed [DW-1:0] part [NMUL];

    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        logic signed [DW-1:0] xs;
        logic signed [TW-1:0] ws;
        assign xs = (g / 2 == 1) ? d_im : d_re;
        assign ws = (g % 2 == 1) ? w_im : w_re;
        dif_bfly_tmul #(.DW(DW), .TW(TW), .FRAC(FRAC)) i_tmul (
            .x(xs),
            .w(ws),
            .y(part[g])
        );
    end

    always_comb begin
        r_re = part[0] - part[3];
        r_im = part[1] + part[2];
    end

endmodule

// File: rtl/dif_bfly_r2.sv
module dif_bfly_r2 #(
    parameter int unsigned DW   = dif_bfly_pkg::DATA_W_DEF,
    parameter int unsigned TW   = dif_bfly_pkg::TWID_W_DEF,
    parameter int unsigned FRAC = dif_bfly_pkg::FRAC_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] p_re,
    input  logic signed [DW-1:0] p_im,
    input  logic signed [DW-1:0] q_re,
    input  logic signed [DW-1:0] q_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] up_re,
    output logic signed [DW-1:0] up_im,
    output logic signed [DW-1:0] lo_re,
    output logic signed [DW-1:0] lo_im
);

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] sum_re;
        logic signed [DW-1:0] sum_im;
        logic signed [DW-1:0] dif_re;
        logic signed [DW-1:0] dif_im;
        logic signed [TW-1:0] tw_re;
        logic signed [TW-1:0] tw_im;
    } as_stage_t;

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] up_re;
        logic signed [DW-1:0] up_im;
        logic signed [DW-1:0] lo_re;
        logic signed [DW-1:0] lo_im;
    } mul_stage_t;

    as_stage_t  as_d, as_q;
    mul_stage_t mul_d, mul_q;

    logic signed [DW-1:0] c_sum_re, c_sum_im, c_dif_re, c_dif_im;
    logic signed [DW-1:0] c_rot_re, c_rot_im;

    dif_bfly_addsub #(.DW(DW)) i_addsub (
        .p_re  (p_re),
        .p_im  (p_im),
        .q_re  (q_re),
        .q_im  (q_im),
        .sum_re(c_sum_re),
        .sum_im(c_sum_im),
        .dif_re(c_dif_re),
        .dif_im(c_dif_im)
    );

    dif_bfly_twid #(.DW(DW), .TW(TW), .FRAC(FRAC)) i_twid (
        .d_re(as_q.dif_re),
        .d_im(as_q.dif_im),
        .w_re(as_q.tw_re),
        .w_im(as_q.tw_im),
        .r_re(c_rot_re),
        .r_im(c_rot_im)
    );

    // Next-state logic: each stage loads only when its incoming valid is set.
    always_comb begin
        as_d     = as_q;
        as_d.vld = in_valid;
        if (in_valid) begin
            as_d.sum_re = c_sum_re;
            as_d.sum_im = c_sum_im;
            as_d.dif_re = c_dif_re;
            as_d.dif_im = c_dif_im;
            as_d.tw_re  = w_re;
            as_d.tw_im  = w_im;
        end

        mul_d     = mul_q;
        mul_d.vld = as_q.vld;
        if (as_q.vld) begin
            mul_d.up_re = as_q.sum_re;
            mul_d.up_im = as_q.sum_im;
            mul_d.lo_re = c_rot_re;
            mul_d.lo_im = c_rot_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q  <= '0;
            mul_q <= '0;
        end else begin
            as_q  <= as_d;
            mul_q <= mul_d;
        end
    end

    assign out_valid = mul_q.vld;
    assign up_re     = mul_q.up_re;
    assign up_im     = mul_q.up_im;
    assign lo_re     = mul_q.lo_re;
    assign lo_im     = mul_q.lo_im;

endmodule

// File: rtl/dif_bfly_r2_chk.sv
module dif_bfly_r2_chk #(
    parameter int unsigned DW   = dif_bfly_pkg::DATA_W_DEF,
    parameter int unsigned TW   = dif_bfly_pkg::TWID_W_DEF,
    parameter int unsigned FRAC = dif_bfly_pkg::FRAC_W_DEF
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] p_re,
    input logic signed [DW-1:0] p_im,
    input logic signed [DW-1:0] q_re,
    input logic signed [DW-1:0] q_im,
    input logic signed [TW-1:0] w_re,
    input logic signed [TW-1:0] w_im,
    input logic                 out_valid,
    input logic signed [DW-1:0] up_re,
    input logic signed [DW-1:0] up_im,
    input logic signed [DW-1:0] lo_re,
    input logic signed [DW-1:0] lo_im
);

    // Edges seen since reset was released, saturating at 2.
    logic [1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end

    function automatic int wrapw(input int v);
        int m;
        m = v & ((1 << DW) - 1);
        return (m >= (1 << (DW - 1))) ? m - (1 << DW) : m;
    endfunction

    function automatic int cut(input int x, input int w);
        return wrapw((x * w) >>> FRAC);
    endfunction

    function automatic int model_up(input int a, input int b);
        return wrapw(a + b);
    endfunction

    function automatic int model_lo_re(input int ar, input int ai, input int br,
                                       input int bi, input int wr, input int wi);
        int dr, di;
        dr = wrapw(ar - br);
        di = wrapw(ai - bi);
        return wrapw(cut(dr, wr) - cut(di, wi));
    endfunction

    function automatic int model_lo_im(input int ar, input int ai, input int br,
                                       input int bi, input int wr, input int wi);
        int dr, di;
        dr = wrapw(ar - br);
        di = wrapw(ai - bi);
        return wrapw(cut(dr, wi) + cut(di, wr));
    endfunction

    // R1: outputs cleared on every edge seen inside reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!out_valid && up_re == 0 && up_im == 0 &&
                                      lo_re == 0 && lo_im == 0)
                else $error("R1 outputs not cleared in reset");
        end
    end

    // R6: valid travels through exactly two registers
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2: upper output is the wrapped sum of the inputs two edges back
    a_r2_upper_re: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2 && out_valid) |->
        (int'(up_re) == model_up(int'($past(p_re, 2)), int'($past(q_re, 2)))));

    a_r2_upper_im: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2 && out_valid) |->
        (int'(up_im) == model_up(int'($past(p_im, 2)), int'($past(q_im, 2)))));

    // R4: lower output is the truncated rotation of the difference
    a_r4_lower_re: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2 && out_valid) |->
        (int'(lo_re) == model_lo_re(int'($past(p_re, 2)), int'($past(p_im, 2)),
                                    int'($past(q_re, 2)), int'($past(q_im, 2)),
                                    int'($past(w_re, 2)), int'($past(w_im, 2)))));

    a_r4_lower_im: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd2 && out_valid) |->
        (int'(lo_im) == model_lo_im(int'($past(p_re, 2)), int'($past(p_im, 2)),
                                    int'($past(q_re, 2)), int'($past(q_im, 2)),
                                    int'($past(w_re, 2)), int'($past(w_im, 2)))));

    // R8: data outputs frozen whenever no result is presented
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && !out_valid) |->
        ($stable(up_re) && $stable(up_im) && $stable(lo_re) && $stable(lo_im)));

endmodule

bind dif_bfly_r2 dif_bfly_r2_chk #(.DW(DW), .TW(TW), .FRAC(FRAC)) i_chk (.*);

// File: tb/test_dif_bfly_r2.sv
`timescale 1ns/1ps
module test_dif_bfly_r2;

    localparam int DW = 4;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [DW-1:0] p_re, p_im, q_re, q_im;
    logic signed [TW-1:0] w_re, w_im;
    logic out_valid;
    logic signed [DW-1:0] up_re, up_im, lo_re, lo_im;

    always #2.5 clk = ~clk;

    dif_bfly_r2 i_dif_bfly_r2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .p_re(p_re), .p_im(p_im), .q_re(q_re), .q_im(q_im),
        .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid),
        .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im)
    );

    typedef struct {
        int due;
        int ur, ui, lr, li;
    } exp_t;

    exp_t exp_q[$];
    int   last_ur, last_ui, last_lr, last_li;
    int   n_chk  = 0;
    int   n_fail = 0;
    int   step_n = 0;

    function automatic int wrap4(input int v);
        int m;
        m = v & 15;
        return (m >= 8) ? m - 16 : m;
    endfunction

    function automatic int trunc_prod(input int x, input int w);
        // floor(x*w / 4), then keep a 4-bit two's-complement window
        int p, f;
        p = x * w;
        f = (p >= 0) ? p / 4 : -((-p + 3) / 4);
        return wrap4(f);
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (step %0d)", req, what, act, expv, step_n);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One cycle: compare outputs, then apply reset level and new inputs.
    task automatic step(input bit rst_hi, input bit v, input int ar, input int ai,
                        input int br, input int bi, input int wr, input int wi,
                        input string tag);
        bit ev;
        exp_t e;
        @(negedge clk);
        ev = (exp_q.size() != 0) && (exp_q[0].due == step_n);
        if (ev) begin
            e = exp_q.pop_front();
            last_ur = e.ur; last_ui = e.ui; last_lr = e.lr; last_li = e.li;
        end
        check(rst_n ? "R6" : "R1", "out_valid", int'(out_valid === 1'b1), int'(ev));
        check(ev ? "R2" : (rst_n ? "R8" : "R1"), {tag, " up_re"}, int'(up_re), last_ur);
        check(ev ? "R2" : (rst_n ? "R8" : "R1"), {tag, " up_im"}, int'(up_im), last_ui);
        check(ev ? "R4" : (rst_n ? "R8" : "R1"), {tag, " lo_re"}, int'(lo_re), last_lr);
        check(ev ? "R4" : (rst_n ? "R8" : "R1"), {tag, " lo_im"}, int'(lo_im), last_li);

        rst_n = rst_hi;
        if (!rst_hi) begin
            exp_q.delete();
            last_ur = 0; last_ui = 0; last_lr = 0; last_li = 0;
        end
        in_valid = v;
        p_re = 4'(ar); p_im = 4'(ai); q_re = 4'(br); q_im = 4'(bi);
        w_re = 4'(wr); w_im = 4'(wi);
        if (rst_hi && v) begin
            int dr, di;
            dr = wrap4(ar - br);
            di = wrap4(ai - bi);
            e.due = step_n + 2;
            e.ur  = wrap4(ar + br);
            e.ui  = wrap4(ai + bi);
            e.lr  = wrap4(trunc_prod(dr, wr) - trunc_prod(di, wi));
            e.li  = wrap4(trunc_prod(dr, wi) + trunc_prod(di, wr));
            exp_q.push_back(e);
        end
        step_n++;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1;
        p_re = 4'sd3; p_im = 4'sd1; q_re = 4'sd2; q_im = 4'sd1;
        w_re = 4'sd4; w_im = 4'sd0;
        last_ur = 0; last_ui = 0; last_lr = 0; last_li = 0;

        // R1: valid pulses during reset produce nothing
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 5, -3, 1, 2, 4, 4, "R1 in-reset");

        // R2: plain sums, unit twiddle
        step(1'b1, 1'b1, 3, -2, 2, -5, 4, 0, "R2 basic");
        step(1'b1, 1'b1, -4, 6, 1, -1, 0, 4, "R2 j-twiddle");
        // R3: wrapping difference and sum
        step(1'b1, 1'b1, 7, -8, -8, 7, 4, 0, "R3 diff wrap");
        step(1'b1, 1'b1, 7, 7, 1, 1, 4, 0, "R3 sum wrap");
        step(1'b1, 1'b1, -8, -8, -1, -1, 2, -2, "R3 neg wrap");
        // R5: floor truncation and window overflow
        step(1'b1, 1'b1, 0, 0, 1, 0, 1, 0, "R5 floor -1");
        step(1'b1, 1'b1, -3, 0, 0, 0, 1, 0, "R5 floor -3");
        step(1'b1, 1'b1, -8, 0, 0, 0, -8, 0, "R5 overflow");
        step(1'b1, 1'b1, 5, 3, -2, -4, -8, 7, "R5 mixed");
        // R8: idle cycles with changing inputs
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, i - 4, 3 - i, 2 * i - 5, i, i + 2, -i, "R8 idle");

        // R7: back-to-back and gapped streams
        for (int i = 0; i < 400; i++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(1'b1, v, $urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8,
                 $urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8,
                 $urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8, "R7 stream");
        end

        // R1: reset with transfers in flight
        step(1'b1, 1'b1, 6, 2, -1, 3, 3, -2, "R1 pre-reset");
        step(1'b1, 1'b1, -5, 4, 2, 2, -4, 1, "R1 pre-reset");
        step(1'b0, 1'b1, 1, 1, 1, 1, 1, 1, "R1 reset");
        step(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(1'b1, 1'b0, 2, 2, 2, 2, 2, 2, "R1 release");
        step(1'b1, 1'b1, 2, -3, -6, 5, 4, -4, "R2 after reset");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, 0, 0, 0, 0, 0, "R8 drain");

        report();
    end

endmodule